// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block gives software control over a bank of general-purpose pins through a small 32-bit register bus. Each pin is either a plain I/O (driven as an output or read as an input) or an interrupt source. An interrupt source is sensed on a level or on an edge, with selectable polarity. Every pin has a pending flag and a mask bit, and one interrupt line is raised while any unmasked pin has its flag set.

Incoming pin levels pass through a two-flop synchronizer before the input register and the interrupt detector see them. Pending flags are cleared by writing ones to a clear register. Masking and unmasking go through two separate write-only registers, so no register on the bus ever needs a read-modify-write. A filter-enable register is kept for software, but it only stores and reads back its value.

The bus is a request/response pair with no back-pressure. The block takes every cycle with `req_valid` high, so it has no ready signal. A read returns `rsp_valid` with its data exactly one cycle after the request. A write produces no response. The pin and interrupt signals are plain levels.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all pins are general inputs (`pin_oe` = 0). Polarity is positive, sensing is by level, every mask bit reads 1 (masked), no pending flag is set, the output data reads 0 and `irq` is 0.
- R2: Byte offsets are: mode 0x00, direction 0x04, output data 0x08, input data 0x0C, pending 0x10, clear 0x14, mask 0x18, unmask 0x1C, polarity 0x20, sense 0x24, filter 0x28. The mode, direction, output data, polarity, sense and filter registers read back what was written. A read raises `rsp_valid` with its data in the next cycle and at no other time.
- R3: `pin_out` carries the output data register. A bit of `pin_oe` is 1 only when that pin's mode bit is 0 (plain I/O) and its direction bit is 1.
- R4: The input data register returns `pin_in` after two clock edges of synchronization. A read captured on the first or second edge after a pin change returns the old level; a read captured on the third edge returns the new level.
- R5: A pin with mode 1 and sense bit 0 has a pending flag that follows its active level: high when the polarity bit is 0, low when it is 1. Writing 1 to the clear register has no effect while that level persists.
- R6: A pin with mode 1 and sense bit 1 sets its pending flag on a rising edge (polarity 0) or a falling edge (polarity 1). The flag stays set after the pin returns. Writing 1 to that bit of the clear register clears it; writing 0 does not.
- R7: Writing the mask register masks each pin whose bit is 0 and leaves pins whose bit is 1 unchanged. Writing 1 to a bit of the unmask register unmasks that pin. The mask register reads back the current mask state (1 = masked).
- R8: `irq` is 1 exactly when some pin has both its pending flag set and its mask bit at 0.
- R9: A pin in plain I/O mode (mode bit 0) never sets its pending flag, whatever its input does.
- R10: Writes to the input data and pending registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach are the ones where an interrupt flag must refuse a change. One is a level-sensed flag that is written to clear while its level is still active. Another is an edge-sensed flag that must hold after the pin goes back. The stimulus holds a pin at its active level and writes the clear register. It then releases the pin and reads the pending register through the bus. Pin changes are placed so that reads land on the first, second and third edges after a change, which shows the exact synchronizer latency. Polarity is always programmed before the mode bit, so that flipping the sense of an idle pin cannot look like an edge.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_FILT   = 6'h28;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] act;
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  assign act = lvl_i ^ pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= act;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic nxt;
    always_comb begin
      if (!mode_i[i])      nxt = 1'b0;
      else if (sense_i[i]) nxt = (pend_q[i] & ~clr_i[i]) | (act[i] & ~prev_q[i]);
      else                 nxt = act[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= nxt;
    end
  end

  assign pend_o = pend_q;

  AST_GEN_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & ~$past(mode_i)) == '0); // R9
  AST_LVL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(mode_i & ~sense_i & act)) == $past(mode_i & ~sense_i & act)); // R5
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q & $past(pend_q & mode_i & sense_i & ~clr_i)) == $past(pend_q & mode_i & sense_i & ~clr_i)); // R6
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NPINS-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [NPINS-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] mode_q, dir_q, dout_q, pol_q, sense_q, filt_q, mask_q;
  logic [NPINS-1:0] din_sync, pend, clr_vec, rd_mux;
  logic wr_en, rd_en;

  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(din_sync)
  );

  assign clr_vec = (wr_en && req_addr == OFS_CLR) ? req_wdata : '0;

  gpio_irq_core #(.W(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_i(din_sync), .mode_i(mode_q),
    .pol_i(pol_q), .sense_i(sense_q), .clr_i(clr_vec), .pend_o(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      pol_q   <= '0;
      sense_q <= '0;
      filt_q  <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      case (req_addr)
        OFS_MODE:   mode_q  <= req_wdata;
        OFS_DIR:    dir_q   <= req_wdata;
        OFS_DOUT:   dout_q  <= req_wdata;
        OFS_POL:    pol_q   <= req_wdata;
        OFS_SENSE:  sense_q <= req_wdata;
        OFS_FILT:   filt_q  <= req_wdata;
        OFS_MASK:   mask_q  <= mask_q | ~req_wdata;
        OFS_UNMASK: mask_q  <= mask_q & ~req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      OFS_MODE:  rd_mux = mode_q;
      OFS_DIR:   rd_mux = dir_q;
      OFS_DOUT:  rd_mux = dout_q;
      OFS_DIN:   rd_mux = din_sync;
      OFS_PEND:  rd_mux = pend;
      OFS_MASK:  rd_mux = mask_q;
      OFS_POL:   rd_mux = pol_q;
      OFS_SENSE: rd_mux = sense_q;
      OFS_FILT:  rd_mux = filt_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q & ~mode_q;
  assign irq     = |(pend & ~mask_q);

  AST_RSP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid); // R2
  AST_UNMASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == OFS_UNMASK) |=> (mask_q & $past(req_wdata)) == '0); // R7
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == OFS_MASK) |=> (~mask_q & $past(mask_q | ~req_wdata)) == '0); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0)); // R8
endmodule

// File: tb/gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_ctrl_tb_top;
  import gpio_ctrl_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  gpio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing responses act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pin_oe", pin_oe, 32'd0);
    rd(OFS_MODE, 32'd0, "R1 mode");
    rd(OFS_DIR, 32'd0, "R1 dir");
    rd(OFS_DOUT, 32'd0, "R1 dout");
    rd(OFS_POL, 32'd0, "R1 pol");
    rd(OFS_SENSE, 32'd0, "R1 sense");
    rd(OFS_MASK, 32'hFFFF_FFFF, "R1 mask");
    rd(OFS_PEND, 32'd0, "R1 pend");

    // R2 register readback
    wr(OFS_DIR, 32'hA5A5_0F0F);
    wr(OFS_DOUT, 32'h1234_5678);
    wr(OFS_POL, 32'h0F0F_F0F0);
    wr(OFS_SENSE, 32'h5555_AAAA);
    wr(OFS_FILT, 32'hDEAD_BEEF);
    rd(OFS_DIR, 32'hA5A5_0F0F, "R2 dir");
    rd(OFS_DOUT, 32'h1234_5678, "R2 dout");
    rd(OFS_POL, 32'h0F0F_F0F0, "R2 pol");
    rd(OFS_SENSE, 32'h5555_AAAA, "R2 sense");
    rd(OFS_FILT, 32'hDEAD_BEEF, "R2 filt");
    wr(OFS_POL, 32'd0);
    wr(OFS_SENSE, 32'd0);
    // R3 output drive
    chk("R3 pin_out", pin_out, 32'h1234_5678);
    chk("R3 pin_oe gen", pin_oe, 32'hA5A5_0F0F);
    wr(OFS_MODE, 32'h0000_000F);
    chk("R3 pin_oe irq-mode", pin_oe, 32'hA5A5_0F00);
    rd(OFS_MODE, 32'h0000_000F, "R2 mode");
    wr(OFS_MODE, 32'd0);

    // R4 synchronizer latency, R9 plain I/O never pends
    pin_in = 32'h3C3C_0000;
    rd(OFS_DIN, 32'd0, "R4 edge1 old");
    rd(OFS_DIN, 32'd0, "R4 edge2 old");
    rd(OFS_DIN, 32'h3C3C_0000, "R4 edge3 new");
    rd(OFS_PEND, 32'd0, "R9 no pend in gen mode");

    // R10 read-only registers
    wr(OFS_DIN, 32'hFFFF_FFFF);
    wr(OFS_PEND, 32'hFFFF_FFFF);
    rd(OFS_DIN, 32'h3C3C_0000, "R10 din");
    rd(OFS_PEND, 32'd0, "R10 pend");
    pin_in = 32'd0;
    idle(4);

    // R5 level, active high, pin0
    wr(OFS_UNMASK, 32'h1);
    wr(OFS_MODE, 32'h1);
    pin_in = 32'h1;
    idle(4);
    rd(OFS_PEND, 32'h1, "R5 level high pend");
    chk("R8 irq on unmasked pend", {31'd0, irq}, 32'd1);
    wr(OFS_CLR, 32'h1);
    idle(2);
    rd(OFS_PEND, 32'h1, "R5 clear ignored while active");
    pin_in = 32'h0;
    idle(4);
    rd(OFS_PEND, 32'h0, "R5 level released");
    chk("R8 irq off", {31'd0, irq}, 32'd0);
    // R5 level, active low, pin1 (masked)
    wr(OFS_POL, 32'h2);
    wr(OFS_MODE, 32'h3);
    idle(4);
    rd(OFS_PEND, 32'h2, "R5 level low pend");
    chk("R8 masked pend no irq", {31'd0, irq}, 32'd0);
    pin_in = 32'h2;
    idle(4);
    rd(OFS_PEND, 32'h0, "R5 level low released");

    // R6 rising edge pin4
    wr(OFS_SENSE, 32'h10);
    wr(OFS_MODE, 32'h13);
    idle(3);
    rd(OFS_PEND, 32'h0, "R6 no spurious edge");
    pin_in = 32'h12;
    idle(4);
    rd(OFS_PEND, 32'h10, "R6 rising sets");
    pin_in = 32'h02;
    idle(4);
    rd(OFS_PEND, 32'h10, "R6 held after return");
    wr(OFS_CLR, 32'h0);
    rd(OFS_PEND, 32'h10, "R6 clear zero no effect");
    wr(OFS_CLR, 32'h10);
    rd(OFS_PEND, 32'h0, "R6 clear one");
    // R6 falling edge pin5: polarity before mode
    wr(OFS_POL, 32'h22);
    wr(OFS_SENSE, 32'h30);
    wr(OFS_MODE, 32'h33);
    idle(3);
    rd(OFS_PEND, 32'h0, "R6 pol change no edge");
    pin_in = 32'h22;
    idle(4);
    rd(OFS_PEND, 32'h0, "R6 rising ignored when falling");
    pin_in = 32'h02;
    idle(4);
    rd(OFS_PEND, 32'h20, "R6 falling sets");
    wr(OFS_CLR, 32'h20);
    rd(OFS_PEND, 32'h0, "R6 falling cleared");

    // R7 / R8 mask handling
    wr(OFS_UNMASK, 32'h30);
    rd(OFS_MASK, 32'hFFFF_FFCE, "R7 unmask");
    pin_in = 32'h12;
    idle(4);
    chk("R8 irq pin4", {31'd0, irq}, 32'd1);
    wr(OFS_MASK, ~32'h10);
    chk("R7 masked irq drops", {31'd0, irq}, 32'd0);
    rd(OFS_MASK, 32'hFFFF_FFDE, "R7 mask one pin");
    rd(OFS_PEND, 32'h10, "R8 pend kept while masked");
    wr(OFS_UNMASK, 32'h10);
    chk("R7 unmask irq back", {31'd0, irq}, 32'd1);
    wr(OFS_CLR, 32'h10);
    chk("R8 irq after clear", {31'd0, irq}, 32'd0);
    finish_run();
  end
endmodule